// File: doc/BRIEF.md
# Card Attribute Register Bank

This block holds the attribute-space configuration registers of a removable-card storage function. A host reaches it through an 8-bit read/write port that carries an attribute-space address. Addresses below a configurable window base return bytes of a small card-information ROM, or zero beyond the end of that ROM. Addresses from the base upward reach four configuration registers: option, configuration status, pin replacement and socket/copy.

The block also turns the storage engine's interrupt request into the card interrupt output, gated by the option and device-control state. When the option register or the device-control byte requests a soft reset, the block returns all of its state to zero and raises a one-cycle soft-reset pulse for the rest of the card. Writes update state on the clock edge that samples them. Reads are registered and return the value at the edge that samples the read strobe.

Top module: `cardcfg_regbank`

## Requirements
- R1: After reset, and after any soft reset, the option byte, status byte, both pin bits, the interrupt-enable control bit and the soft-reset pulse are all zero. A status read then returns 0x00, and a pin-replacement read returns 0x0C.
- R2: A write to base+0x00 stores the written value ANDed with 0xCF. Bits 5:0 of the stored option drive `addr_mode`, and bit 6 drives `level_irq`. A read of base+0x00 returns the stored byte.
- R3: A write to base+0x00 with bit 7 set clears all state on that clock edge and drives `soft_rst` high for exactly the following cycle.
- R4: A write to base+0x02 keeps the stored bits under mask 0x82 and loads the bits under mask 0x74 from the written value. Bits 3 and 0 stay zero.
- R5: A status write whose bit 2 (power-down) differs from the stored bit 2 sets the ready-change bit, which reads as bit 5 (0x20) of the pin-replacement register. A status write that leaves bit 2 unchanged does not set it.
- R6: A status read returns bit 1 (interrupt pending) as 0 while the interrupt-enable control bit is set. Otherwise the stored bit is returned.
- R7: A pin-replacement read returns the ready-change bit (0x20) ORed with 0x0C. A write to base+0x04 leaves the ready-change bit unchanged and loads bit 1 of the value into `mrdy_out`.
- R8: Reads of base+0x06, and of any other offset at or above the base that is not 0x00, 0x02, 0x04 or 0x06, return 0x00. Writes to those offsets change no state.
- R9: `card_irq` is high exactly when, one cycle earlier, the pending bit was clear, the interrupt-enable control bit was clear and option bit 7 was clear.
- R10: A read at an address below the base returns the ROM byte (7*addr + 3) mod 256 when addr < ROM_BYTES. Otherwise it returns 0x00.
- R11: A device-control write with `devctl_srst` high acts as a soft reset in the same way as R3. Without it, the write stores `devctl_ien` as the interrupt-enable control bit.
- R12: The pending bit (status bit 1) takes the value of `eng_irq` on every clock edge that is not a reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| attr_addr | input | ADDR_W | Attribute-space byte address |
| attr_wr | input | 1 | Write strobe for attribute space |
| attr_rd | input | 1 | Read strobe for attribute space |
| attr_wdata | input | 8 | Write data |
| attr_rdata | output | 8 | Registered read data |
| devctl_wr | input | 1 | Device-control byte write strobe |
| devctl_ien | input | 1 | Interrupt-enable bit of the device-control byte |
| devctl_srst | input | 1 | Soft-reset bit of the device-control byte |
| eng_irq | input | 1 | Interrupt request level from the storage engine |
| card_irq | output | 1 | Registered card interrupt output |
| soft_rst | output | 1 | One-cycle soft-reset pulse |
| addr_mode | output | 6 | Addressing-mode field of the option byte |
| level_irq | output | 1 | Level-interrupt select of the option byte |
| mrdy_out | output | 1 | Bit 1 of the pin-replacement register |

## Verification
A write changes register state at the edge that samples it. A read of that state is therefore valid one edge after the read strobe is sampled, so the earliest read-back lands two edges after the write. `card_irq` trails the state that feeds it by one more edge. A change on `eng_irq` therefore reaches `card_irq` two edges later, and a device-control or option write reaches it one edge after its own write edge. The bench drives inputs on falling edges and samples on the falling edge after the edge where each result is due. It waits the extra edges explicitly before every interrupt check.

// File: rtl/cardcfg_pkg.sv
`timescale 1ns/1ps
// cardcfg_pkg: shared types, bit positions and masks of the attribute
// register bank. Assumes byte-wide registers throughout.
package cardcfg_pkg;

    // Which attribute-space target an address selects
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ROM,
        SEL_OPT,
        SEL_STAT,
        SEL_PIN,
        SEL_SOCK
    } attr_sel_e;

    // Register offsets from the window base
    localparam int OFS_OPT  = 0;
    localparam int OFS_STAT = 2;
    localparam int OFS_PIN  = 4;
    localparam int OFS_SOCK = 6;

    // Option register
    localparam logic [7:0] OPT_STORE_MASK = 8'hCF;
    localparam int         OPT_SRST_BIT   = 7;
    localparam int         OPT_LEVEL_BIT  = 6;

    // Status register
    localparam logic [7:0] STAT_HOLD_MASK = 8'h80;
    localparam logic [7:0] STAT_LOAD_MASK = 8'h74;
    localparam int         STAT_PEND_BIT  = 1;
    localparam int         STAT_PWDN_BIT  = 2;

    // Pin replacement register
    localparam int         PIN_RDY_BIT    = 5;
    localparam int         PIN_MRDY_BIT   = 1;
    localparam logic [7:0] PIN_FIXED      = 8'h0C;

    // Card-information byte at a given index
    function automatic logic [7:0] info_byte(input int unsigned idx);
        int unsigned v;
        v = idx * 7 + 3;
        return v[7:0];
    endfunction

endpackage

// File: rtl/cardcfg_decode.sv
`timescale 1ns/1ps
// cardcfg_decode: maps an attribute-space address to a target.
// Addresses below CFG_BASE address the information ROM, which has
// ROM_BYTES entries. Addresses from CFG_BASE upward address the four
// registers at even offsets. Assumes ROM_BYTES <= CFG_BASE and
// ROM_BYTES >= 2.
module cardcfg_decode
    import cardcfg_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int CFG_BASE  = 512,
    parameter int ROM_BYTES = 48,
    parameter int IDX_W     = $clog2(ROM_BYTES)
) (
    input  logic [ADDR_W-1:0] addr,
    output attr_sel_e         sel,
    output logic [IDX_W-1:0]  rom_idx
);

    localparam logic [ADDR_W-1:0] BASE_A    = ADDR_W'(CFG_BASE);
    localparam logic [ADDR_W-1:0] ROM_END_A = ADDR_W'(ROM_BYTES);

    logic [ADDR_W-1:0] offset;

    // Offset inside the register window
    assign offset  = addr - BASE_A;
    assign rom_idx = addr[IDX_W-1:0];

    // Select the target for the current address
    always_comb begin
        sel = SEL_NONE;
        if (addr < BASE_A) begin
            if (addr < ROM_END_A) begin
                sel = SEL_ROM;
            end
        end else begin
            case (offset)
                ADDR_W'(OFS_OPT):  sel = SEL_OPT;
                ADDR_W'(OFS_STAT): sel = SEL_STAT;
                ADDR_W'(OFS_PIN):  sel = SEL_PIN;
                ADDR_W'(OFS_SOCK): sel = SEL_SOCK;
                default:           sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/cardcfg_info_rom.sv
`timescale 1ns/1ps
// cardcfg_info_rom: a constant card-information table of ROM_BYTES
// entries, built at elaboration from the package formula. Indices past
// the table return zero.
module cardcfg_info_rom
    import cardcfg_pkg::*;
#(
    parameter int ROM_BYTES = 48,
    parameter int IDX_W     = $clog2(ROM_BYTES)
) (
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       data
);

    logic [7:0] rom_tbl [ROM_BYTES];

    // Fill each table entry with its constant byte
    for (genvar i = 0; i < ROM_BYTES; i++) begin : g_entry
        assign rom_tbl[i] = info_byte(i);
    end

    // Guarded table lookup
    always_comb begin
        if (int'(idx) < ROM_BYTES) begin
            data = rom_tbl[idx];
        end else begin
            data = 8'h00;
        end
    end

endmodule

// File: rtl/cardcfg_state.sv
`timescale 1ns/1ps
// cardcfg_state: option, status, pin and control state plus soft-reset
// generation. Each write lands on the clock edge that samples it. A soft
// reset (option bit 7, or the device-control reset bit) wins over any
// other update on the same edge.
module cardcfg_state
    import cardcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  attr_sel_e  sel,
    input  logic       attr_wr,
    input  logic [7:0] attr_wdata,
    input  logic       devctl_wr,
    input  logic       devctl_ien,
    input  logic       devctl_srst,
    input  logic       eng_irq,
    output logic [7:0] opt_q,
    output logic [7:0] stat_q,
    output logic       pin_rdy_q,
    output logic       pin_mrdy_q,
    output logic       ctrl_ien_q,
    output logic       soft_rst
);

    logic       opt_wr;
    logic       stat_wr;
    logic       pin_wr;
    logic       card_reset;
    logic       pwdn_flip;
    logic [7:0] stat_next;

    // Per-register write strobes and the soft-reset request
    always_comb begin
        opt_wr     = attr_wr && (sel == SEL_OPT);
        stat_wr    = attr_wr && (sel == SEL_STAT);
        pin_wr     = attr_wr && (sel == SEL_PIN);
        card_reset = (opt_wr && attr_wdata[OPT_SRST_BIT])
                   || (devctl_wr && devctl_srst);
        pwdn_flip  = stat_wr && (attr_wdata[STAT_PWDN_BIT] != stat_q[STAT_PWDN_BIT]);
    end

    // Next status: merge masked bits, pending follows the engine
    always_comb begin
        stat_next = stat_q;
        if (stat_wr) begin
            stat_next = (stat_q & STAT_HOLD_MASK) | (attr_wdata & STAT_LOAD_MASK);
        end
        stat_next[STAT_PEND_BIT] = eng_irq;
    end

    // Option register
    always_ff @(posedge clk) begin
        if (!rst_n || card_reset) begin
            opt_q <= 8'h00;
        end else if (opt_wr) begin
            opt_q <= attr_wdata & OPT_STORE_MASK;
        end
    end

    // Status register
    always_ff @(posedge clk) begin
        if (!rst_n || card_reset) begin
            stat_q <= 8'h00;
        end else begin
            stat_q <= stat_next;
        end
    end

    // Pin replacement: ready-change latch and bit 1
    always_ff @(posedge clk) begin
        if (!rst_n || card_reset) begin
            pin_rdy_q  <= 1'b0;
            pin_mrdy_q <= 1'b0;
        end else begin
            if (pwdn_flip) begin
                pin_rdy_q <= 1'b1;
            end
            if (pin_wr) begin
                pin_mrdy_q <= attr_wdata[PIN_MRDY_BIT];
            end
        end
    end

    // Device-control interrupt-enable bit
    always_ff @(posedge clk) begin
        if (!rst_n || card_reset) begin
            ctrl_ien_q <= 1'b0;
        end else if (devctl_wr) begin
            ctrl_ien_q <= devctl_ien;
        end
    end

    // One-cycle soft-reset pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_rst <= 1'b0;
        end else begin
            soft_rst <= card_reset;
        end
    end

endmodule

// File: rtl/cardcfg_irq.sv
`timescale 1ns/1ps
// cardcfg_irq: registered card interrupt. The pending bit has inverted
// sense. The output is high only while pending, interrupt-enable and
// option soft-reset are all clear. Lags its inputs by one edge.
module cardcfg_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic pend,
    input  logic ien,
    input  logic opt_srst,
    output logic card_irq
);

    // Recompute the interrupt on every edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            card_irq <= 1'b0;
        end else begin
            card_irq <= !pend && !ien && !opt_srst;
        end
    end

endmodule

// File: rtl/cardcfg_regbank.sv
`timescale 1ns/1ps
// cardcfg_regbank: attribute-space register bank of a card storage
// function. It joins the address decode, the information ROM, the state
// registers and the interrupt stage, and registers read data on each
// read strobe. Assumes ROM_BYTES <= CFG_BASE and that the window fits
// in ADDR_W bits.
module cardcfg_regbank
    import cardcfg_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int CFG_BASE  = 512,
    parameter int ROM_BYTES = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] attr_addr,
    input  logic              attr_wr,
    input  logic              attr_rd,
    input  logic [7:0]        attr_wdata,
    output logic [7:0]        attr_rdata,
    input  logic              devctl_wr,
    input  logic              devctl_ien,
    input  logic              devctl_srst,
    input  logic              eng_irq,
    output logic              card_irq,
    output logic              soft_rst,
    output logic [5:0]        addr_mode,
    output logic              level_irq,
    output logic              mrdy_out
);

    localparam int IDX_W = $clog2(ROM_BYTES);

    attr_sel_e        sel;
    logic [IDX_W-1:0] rom_idx;
    logic [7:0]       rom_byte;
    logic [7:0]       opt_q;
    logic [7:0]       stat_q;
    logic             pin_rdy_q;
    logic             pin_mrdy_q;
    logic             ctrl_ien_q;
    logic [7:0]       read_val;

    cardcfg_decode #(
        .ADDR_W   (ADDR_W),
        .CFG_BASE (CFG_BASE),
        .ROM_BYTES(ROM_BYTES),
        .IDX_W    (IDX_W)
    ) u_decode (
        .addr   (attr_addr),
        .sel    (sel),
        .rom_idx(rom_idx)
    );

    cardcfg_info_rom #(
        .ROM_BYTES(ROM_BYTES),
        .IDX_W    (IDX_W)
    ) u_rom (
        .idx (rom_idx),
        .data(rom_byte)
    );

    cardcfg_state u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .attr_wr    (attr_wr),
        .attr_wdata (attr_wdata),
        .devctl_wr  (devctl_wr),
        .devctl_ien (devctl_ien),
        .devctl_srst(devctl_srst),
        .eng_irq    (eng_irq),
        .opt_q      (opt_q),
        .stat_q     (stat_q),
        .pin_rdy_q  (pin_rdy_q),
        .pin_mrdy_q (pin_mrdy_q),
        .ctrl_ien_q (ctrl_ien_q),
        .soft_rst   (soft_rst)
    );

    cardcfg_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (stat_q[STAT_PEND_BIT]),
        .ien     (ctrl_ien_q),
        .opt_srst(opt_q[OPT_SRST_BIT]),
        .card_irq(card_irq)
    );

    // Read multiplexer over all attribute targets
    always_comb begin
        read_val = 8'h00;
        case (sel)
            SEL_ROM:  read_val = rom_byte;
            SEL_OPT:  read_val = opt_q;
            SEL_STAT: begin
                read_val = stat_q;
                if (ctrl_ien_q) begin
                    read_val[STAT_PEND_BIT] = 1'b0;
                end
            end
            SEL_PIN: begin
                read_val = PIN_FIXED;
                read_val[PIN_RDY_BIT] = pin_rdy_q;
            end
            default:  read_val = 8'h00;
        endcase
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attr_rdata <= 8'h00;
        end else if (attr_rd) begin
            attr_rdata <= read_val;
        end
    end

    assign addr_mode = opt_q[5:0];
    assign level_irq = opt_q[OPT_LEVEL_BIT];
    assign mrdy_out  = pin_mrdy_q;

endmodule

// File: rtl/cardcfg_regbank_chk.sv
`timescale 1ns/1ps
// cardcfg_regbank_chk: temporal checks on the register bank, attached
// by bind to every instance of the top module.
module cardcfg_regbank_chk #(
    parameter int ADDR_W   = 12,
    parameter int CFG_BASE = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] attr_addr,
    input logic              attr_wr,
    input logic [7:0]        attr_wdata,
    input logic              devctl_wr,
    input logic              devctl_srst,
    input logic              eng_irq,
    input logic              card_irq,
    input logic              soft_rst,
    input logic [5:0]        addr_mode,
    input logic              level_irq,
    input logic              mrdy_out,
    input logic [7:0]        opt_q,
    input logic [7:0]        stat_q,
    input logic              pin_rdy_q,
    input logic              ctrl_ien_q
);

    localparam logic [ADDR_W-1:0] A_OPT  = ADDR_W'(CFG_BASE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(CFG_BASE + 2);
    localparam logic [ADDR_W-1:0] A_SOCK = ADDR_W'(CFG_BASE + 6);

    logic ctl_reset;
    assign ctl_reset = devctl_wr && devctl_srst;

    // R2: option write lands masked
    assert_opt_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (attr_wr && attr_addr == A_OPT && !attr_wdata[7] && !ctl_reset)
        |=> ({level_irq, addr_mode} == ($past(attr_wdata[6:0]) & 7'h4F)));

    // R3: state is clear while the soft-reset pulse is high
    assert_reset_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> (opt_q == 8'h00 && stat_q == 8'h00 && !pin_rdy_q
                      && !mrdy_out && !ctrl_ien_q));

    // R5: power-down change sets ready-change
    assert_pwdn_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (attr_wr && attr_addr == A_STAT && (attr_wdata[2] != stat_q[2]) && !ctl_reset)
        |=> pin_rdy_q);

    // R8: socket writes leave the registers alone
    assert_sock_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (attr_wr && attr_addr == A_SOCK && !devctl_wr)
        |=> ($stable(opt_q) && $stable(mrdy_out) && $stable(pin_rdy_q)));

    // R9: interrupt follows the gating state one edge later
    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (card_irq == $past(!stat_q[1] && !ctrl_ien_q && !opt_q[7])));

    // R12: pending bit tracks the engine request
    assert_pend_track_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !soft_rst) |-> (stat_q[1] == $past(eng_irq)));

endmodule

bind cardcfg_regbank cardcfg_regbank_chk #(
    .ADDR_W  (ADDR_W),
    .CFG_BASE(CFG_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .attr_addr  (attr_addr),
    .attr_wr    (attr_wr),
    .attr_wdata (attr_wdata),
    .devctl_wr  (devctl_wr),
    .devctl_srst(devctl_srst),
    .eng_irq    (eng_irq),
    .card_irq   (card_irq),
    .soft_rst   (soft_rst),
    .addr_mode  (addr_mode),
    .level_irq  (level_irq),
    .mrdy_out   (mrdy_out),
    .opt_q      (opt_q),
    .stat_q     (stat_q),
    .pin_rdy_q  (pin_rdy_q),
    .ctrl_ien_q (ctrl_ien_q)
);

// File: tb/cardcfg_regbank_test.sv
`timescale 1ns/1ps
// Directed bench for cardcfg_regbank: one task per scenario.
module cardcfg_regbank_test;

    localparam int ADDR_W    = 12;
    localparam int CFG_BASE  = 512;
    localparam int ROM_BYTES = 48;
    localparam logic [ADDR_W-1:0] A_OPT  = ADDR_W'(CFG_BASE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(CFG_BASE + 2);
    localparam logic [ADDR_W-1:0] A_PIN  = ADDR_W'(CFG_BASE + 4);
    localparam logic [ADDR_W-1:0] A_SOCK = ADDR_W'(CFG_BASE + 6);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] attr_addr = '0;
    logic              attr_wr = 1'b0;
    logic              attr_rd = 1'b0;
    logic [7:0]        attr_wdata = 8'h00;
    logic [7:0]        attr_rdata;
    logic              devctl_wr = 1'b0;
    logic              devctl_ien = 1'b0;
    logic              devctl_srst = 1'b0;
    logic              eng_irq = 1'b0;
    logic              card_irq;
    logic              soft_rst;
    logic [5:0]        addr_mode;
    logic              level_irq;
    logic              mrdy_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cardcfg_regbank #(
        .ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE), .ROM_BYTES(ROM_BYTES)
    ) uut (
        .clk(clk), .rst_n(rst_n), .attr_addr(attr_addr), .attr_wr(attr_wr),
        .attr_rd(attr_rd), .attr_wdata(attr_wdata), .attr_rdata(attr_rdata),
        .devctl_wr(devctl_wr), .devctl_ien(devctl_ien), .devctl_srst(devctl_srst),
        .eng_irq(eng_irq), .card_irq(card_irq), .soft_rst(soft_rst),
        .addr_mode(addr_mode), .level_irq(level_irq), .mrdy_out(mrdy_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Inputs change on falling edges, one edge per access
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        attr_addr = a; attr_wdata = d; attr_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        attr_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
        attr_addr = a; attr_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        attr_rd = 1'b0;
        d = attr_rdata;
    endtask

    task automatic ctl(input logic ien, input logic srst);
        devctl_ien = ien; devctl_srst = srst; devctl_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        devctl_wr = 1'b0; devctl_srst = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    function automatic logic [7:0] rom_expect(input int a);
        int v;
        v = (a < ROM_BYTES) ? (a * 7 + 3) : 0;
        return v[7:0];
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        check("R1 rdata in reset", attr_rdata, 0);
        check("R1 irq in reset", card_irq, 0);
        check("R1 mode in reset", addr_mode, 0);
        @(negedge clk); rst_n = 1'b1;
        tick(1);
        check("R9 irq after reset", card_irq, 1);
        check("R1 soft_rst idle", soft_rst, 0);
        rd(A_STAT, d); check("R1 status", d, 8'h00);
        rd(A_OPT, d);  check("R1 option", d, 8'h00);
        rd(A_PIN, d);  check("R1 pin", d, 8'h0C);
    endtask

    task automatic t_option();
        logic [7:0] d;
        wr(A_OPT, 8'h7F);
        rd(A_OPT, d); check("R2 masked store", d, 8'h4F);
        check("R2 addr_mode", addr_mode, 6'h0F);
        check("R2 level_irq", level_irq, 1);
        wr(A_OPT, 8'h03);
        rd(A_OPT, d); check("R2 second store", d, 8'h03);
        check("R2 level cleared", level_irq, 0);
    endtask

    task automatic t_opt_reset();
        logic [7:0] d;
        wr(A_OPT, 8'h41);
        wr(A_STAT, 8'h74);
        wr(A_PIN, 8'h02);
        ctl(1'b1, 1'b0);
        rd(A_PIN, d); check("R5 rdy before reset", d, 8'h2C);
        wr(A_OPT, 8'h80);
        check("R3 pulse high", soft_rst, 1);
        check("R3 mrdy cleared", mrdy_out, 0);
        check("R3 mode cleared", addr_mode, 0);
        rd(A_OPT, d);  check("R3 option cleared", d, 8'h00);
        check("R3 pulse one cycle", soft_rst, 0);
        rd(A_STAT, d); check("R1 status after soft reset", d, 8'h00);
        rd(A_PIN, d);  check("R1 pin after soft reset", d, 8'h0C);
        check("R9 irq re-enabled after reset", card_irq, 1);
    endtask

    task automatic t_status();
        logic [7:0] d;
        wr(A_STAT, 8'hFF);
        rd(A_STAT, d); check("R4 merge of 0xFF", d, 8'h74);
        eng_irq = 1'b1; tick(1);
        rd(A_STAT, d); check("R12 pending set", d, 8'h76);
        wr(A_STAT, 8'h00);
        rd(A_STAT, d); check("R4 merge of 0x00 keeps pending", d, 8'h02);
        eng_irq = 1'b0; tick(1);
        rd(A_STAT, d); check("R12 pending cleared", d, 8'h00);
    endtask

    task automatic t_pins();
        logic [7:0] d;
        wr(A_OPT, 8'h80);
        wr(A_STAT, 8'h70);
        rd(A_PIN, d); check("R5 no flip no flag", d, 8'h0C);
        wr(A_STAT, 8'h04);
        rd(A_PIN, d); check("R5 flip sets flag", d, 8'h2C);
        wr(A_PIN, 8'h00);
        rd(A_PIN, d); check("R7 write keeps rdy", d, 8'h2C);
        wr(A_PIN, 8'hFF);
        check("R7 mrdy loaded", mrdy_out, 1);
        rd(A_PIN, d); check("R7 read shape", d, 8'h2C);
        wr(A_PIN, 8'h00);
        check("R7 mrdy cleared", mrdy_out, 0);
    endtask

    task automatic t_hide();
        logic [7:0] d;
        wr(A_OPT, 8'h80);
        eng_irq = 1'b1; tick(1);
        ctl(1'b1, 1'b0);
        rd(A_STAT, d); check("R6 pending hidden", d, 8'h00);
        ctl(1'b0, 1'b0);
        rd(A_STAT, d); check("R6 pending shown", d, 8'h02);
        eng_irq = 1'b0; tick(1);
    endtask

    task automatic t_irq();
        eng_irq = 1'b0; tick(2);
        check("R9 idle irq high", card_irq, 1);
        eng_irq = 1'b1; tick(1);
        check("R9 one edge after request", card_irq, 1);
        tick(1);
        check("R9 pending drops irq", card_irq, 0);
        eng_irq = 1'b0; tick(2);
        check("R9 irq back", card_irq, 1);
        ctl(1'b1, 1'b0);
        tick(1);
        check("R9 enable bit masks irq", card_irq, 0);
        ctl(1'b0, 1'b0);
        tick(1);
        check("R9 unmask", card_irq, 1);
        wr(A_OPT, 8'h45);
        ctl(1'b1, 1'b1);
        check("R11 ctl reset pulse", soft_rst, 1);
        check("R11 option cleared", addr_mode, 0);
        tick(1);
        check("R11 ien not stored on reset", card_irq, 1);
    endtask

    task automatic t_socket();
        logic [7:0] d;
        wr(A_OPT, 8'h42);
        wr(A_STAT, 8'h30);
        wr(A_SOCK, 8'hFF);
        rd(A_SOCK, d); check("R8 socket reads zero", d, 8'h00);
        rd(A_OPT, d);  check("R8 option untouched", d, 8'h42);
        rd(A_STAT, d); check("R8 status untouched", d, 8'h30);
        wr(A_OPT + ADDR_W'(1), 8'hFF);
        rd(A_OPT, d);  check("R8 odd offset ignored", d, 8'h42);
        rd(A_OPT + ADDR_W'(1), d); check("R8 odd offset reads zero", d, 8'h00);
        rd(A_OPT + ADDR_W'(8), d); check("R8 offset 8 reads zero", d, 8'h00);
    endtask

    task automatic t_rom();
        logic [7:0] d;
        int addrs [5] = '{0, 5, ROM_BYTES - 1, ROM_BYTES, CFG_BASE - 1};
        foreach (addrs[k]) begin
            rd(ADDR_W'(addrs[k]), d);
            check("R10 info byte", d, rom_expect(addrs[k]));
        end
    endtask

    initial begin
        tick(3);
        t_reset();
        t_option();
        t_opt_reset();
        t_status();
        t_pins();
        t_hide();
        t_irq();
        t_socket();
        t_rom();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule